// File: doc/BRIEF.md
# Multi-Source PWM Start Trigger Selector

This block decides when each of several pulse-generator channels starts. Every channel owns a configuration word that names one trigger source and the edge polarity to react to on it. Six sources are available: four level bits that software sets through the register port, the output of a reload timer, and an external pin that is synchronized inside the block. Every source keeps a registered copy of its previous value, so a change on it turns into a single-cycle rising or falling edge pulse. Those edge pulses are shared by all channels.

Each channel also has a software start bit. Writing one to it starts the channel on its own, whatever source the channel has selected. Every start is gated by the channel's operation-enable bit. A trigger that arrives while that bit is clear is thrown away and does not start the channel later. The result is one start pulse per channel, one cycle long, that drives the downstream pulse generator.

Top module: `pst_trig_sel`

## Requirements
- R1: After synchronous active-low reset, every start output is 0, and the level, enable and configuration registers read back 0.
- R2: Writing 1 to bit c at address 2 starts channel c with a one-cycle pulse. The pulse is high between the second and third rising clock edges, counting the edge that captured the write as the first. This happens whatever source and edge mode channel c has selected, and address 2 always reads back 0.
- R3: Source codes 0 to 3 select level bit 0 to 3 of address 0. A change written there starts the channels that select it with the same timing as R2.
- R4: Source code 4 selects the timer input. If the timer input changes before clock edge k, the start output is high between edges k+1 and k+2.
- R5: Source code 5 selects the external pin. The pin passes two synchronizer flops, so a change before edge k gives a start output that is high between edges k+2 and k+3.
- R6: Source codes 6 and 7 select no source. A channel set to either one never starts from any hardware edge.
- R7: The edge field encodes 00 as none, 01 as rising only, 10 as falling only and 11 as both edges.
- R8: Each qualifying event gives exactly one start pulse, one clock cycle wide.
- R9: All enabled channels that select the same source and accept the same edge pulse in the same clock cycle.
- R10: While bit c of address 1 is 0, channel c ignores both hardware and software triggers. Setting the bit afterwards produces no late start.
- R11: Address 1 holds the enable bits, one per channel. Address 4+c holds channel c's configuration: the source in bits [2:0] and the edge mode in bits [4:3]. Address 0 holds the four level bits in bits [3:0]. All three read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| tmr_in | input | 1 | Reload-timer output |
| ext_in | input | 1 | External trigger pin, asynchronous |
| start_o | output | NCH | One-cycle start pulse per channel |

## Verification
The bench sweeps every source code against every edge mode. Channels are given staggered settings, and each source is driven up and then down. A channel that decoded the wrong source, swapped the rising and falling masks, or treated codes 6 and 7 as real sources would fire where zero pulses are expected. An external path with one synchronizer stage too few or too many would move the pulse off its expected cycle. Other directed cases cover these faults: a software start that lingers past one cycle or reads back as 1; a disabled channel that latches a trigger and fires once it is enabled; and channels sharing a source that fire in different cycles.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam int NLVL    = 4;
    localparam int NSRC    = NLVL + 2;
    localparam int SRC_W   = 3;
    localparam int EDGE_W  = 2;
    localparam int CFG_W   = SRC_W + EDGE_W;
    localparam int SRC_TMR = NLVL;
    localparam int SRC_EXT = NLVL + 1;

    typedef enum logic [EDGE_W-1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic [EDGE_W-1:0] edge_sel;
        logic [SRC_W-1:0]  src;
    } chan_cfg_t;
endpackage

// File: rtl/pst_regs.sv
module pst_regs
    import pst_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NLVL-1:0]          lvl_o,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           swt_o,
    output chan_cfg_t [NCH-1:0]      cfg_o
);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SWT = ADDR_W'(2);
    localparam int                A_CFG0 = 4;

    typedef struct packed {
        logic [NLVL-1:0]     lvl;
        logic [NCH-1:0]      en;
        logic [NCH-1:0]      swt;
        chan_cfg_t [NCH-1:0] cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_comb begin
        regs_d     = regs_q;
        regs_d.swt = '0;
        if (wr_en) begin
            if (wr_addr == A_LVL) regs_d.lvl = wr_data[NLVL-1:0];
            if (wr_addr == A_EN)  regs_d.en  = wr_data[NCH-1:0];
            if (wr_addr == A_SWT) regs_d.swt = wr_data[NCH-1:0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == ADDR_W'(A_CFG0 + c)) begin
                    regs_d.cfg[c] = wr_data[CFG_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_LVL) rd_data[NLVL-1:0] = regs_q.lvl;
        if (rd_addr == A_EN)  rd_data[NCH-1:0]  = regs_q.en;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == ADDR_W'(A_CFG0 + c)) rd_data[CFG_W-1:0] = regs_q.cfg[c];
        end
    end

    assign lvl_o = regs_q.lvl;
    assign en_o  = regs_q.en;
    assign swt_o = regs_q.swt;
    assign cfg_o = regs_q.cfg;

    AST_SWT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.swt != '0) && !(wr_en && wr_addr == A_SWT) |=> (regs_q.swt == '0)); // R2
    AST_SWT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_SWT) |-> (rd_data == '0)); // R2
endmodule

// File: rtl/pst_src_edge.sv
module pst_src_edge
    import pst_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] lvl_i,
    input  logic            tmr_i,
    input  logic            ext_i,
    output logic [NSRC-1:0] rise_o,
    output logic [NSRC-1:0] fall_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] ext_sh;
        logic              tmr_s;
        logic [NSRC-1:0]   prev;
    } src_t;

    src_t src_d, src_q;
    logic [NSRC-1:0] cur;

    always_comb begin
        cur              = '0;
        cur[NLVL-1:0]    = lvl_i;
        cur[SRC_TMR]     = src_q.tmr_s;
        cur[SRC_EXT]     = src_q.ext_sh[SYNC_N-1];
    end

    generate
        if (SYNC_N > 1) begin : g_sync_chain
            always_comb begin
                src_d        = src_q;
                src_d.ext_sh = {src_q.ext_sh[SYNC_N-2:0], ext_i};
                src_d.tmr_s  = tmr_i;
                src_d.prev   = cur;
            end
        end else begin : g_sync_single
            always_comb begin
                src_d        = src_q;
                src_d.ext_sh = ext_i;
                src_d.tmr_s  = tmr_i;
                src_d.prev   = cur;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign rise_o = cur & ~src_q.prev;
    assign fall_o = ~cur & src_q.prev;

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R8
endmodule

// File: rtl/pst_chan.sv
module pst_chan
    import pst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  chan_cfg_t       cfg_i,
    input  logic            en_i,
    input  logic            swt_i,
    input  logic [NSRC-1:0] rise_i,
    input  logic [NSRC-1:0] fall_i,
    output logic            start_o
);
    logic start_d, start_q;
    logic r_hit, f_hit;

    always_comb begin
        r_hit = 1'b0;
        f_hit = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (cfg_i.src == SRC_W'(k)) begin
                r_hit = rise_i[k];
                f_hit = fall_i[k];
            end
        end
        start_d = en_i & (swt_i
                        | (cfg_i.edge_sel[0] & r_hit)
                        | (cfg_i.edge_sel[1] & f_hit));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_d;
    end

    assign start_o = start_q;

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(en_i)); // R10
    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(swt_i || ((rise_i | fall_i) != '0))); // R3
endmodule

// File: rtl/pst_trig_sel.sv
module pst_trig_sel
    import pst_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tmr_in,
    input  logic              ext_in,
    output logic [NCH-1:0]    start_o
);
    logic [NLVL-1:0]     lvl;
    logic [NCH-1:0]      en;
    logic [NCH-1:0]      swt;
    chan_cfg_t [NCH-1:0] cfg;
    logic [NSRC-1:0]     rise;
    logic [NSRC-1:0]     fall;

    pst_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .lvl_o(lvl), .en_o(en), .swt_o(swt), .cfg_o(cfg)
    );

    pst_src_edge #(.SYNC_N(SYNC_N)) edge_i (
        .clk(clk), .rst_n(rst_n),
        .lvl_i(lvl), .tmr_i(tmr_in), .ext_i(ext_in),
        .rise_o(rise), .fall_o(fall)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pst_chan chan_i (
            .clk(clk), .rst_n(rst_n),
            .cfg_i(cfg[c]), .en_i(en[c]), .swt_i(swt[c]),
            .rise_i(rise), .fall_i(fall),
            .start_o(start_o[c])
        );
    end
endmodule

// File: tb/pst_trig_sel_tb.sv
`timescale 1ns/1ps
module pst_trig_sel_tb_top;
    localparam int NCH = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic tmr_in = 1'b0;
    logic ext_in = 1'b0;
    logic [NCH-1:0] start_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] lvl_v = '0;
    logic tmr_v = 1'b0;
    logic ext_v = 1'b0;
    int cnt [NCH];
    int first [NCH];
    int src_c [NCH];
    int edg_c [NCH];
    logic [NCH-1:0] en_v;
    bit done = 0;

    always #2.5 clk = ~clk;

    pst_trig_sel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_in(tmr_in), .ext_in(ext_in), .start_o(start_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string req);
        @(negedge clk);
        rd_addr = 4'(a);
        #1;
        check(rd_data == 8'(exp), req, int'(rd_data), exp);
    endtask

    // kind 0..3 level bit, 4 timer, 5 ext pin, 8 software start with mask val
    task automatic fire(input int kind, input int val);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin cnt[c] = 0; first[c] = -1; end
        if (kind < 4) begin
            lvl_v[kind] = val[0];
            wr_en = 1'b1; wr_addr = 4'd0; wr_data = {4'd0, lvl_v};
        end else if (kind == 4) begin
            tmr_v = val[0]; tmr_in = tmr_v;
        end else if (kind == 5) begin
            ext_v = val[0]; ext_in = ext_v;
        end else begin
            wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'(val);
        end
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if (start_o[c]) begin
                    cnt[c]++;
                    if (first[c] < 0) first[c] = i;
                end
            end
        end
    endtask

    function automatic string tag_for(input int s, input int e, input int k);
        if (s > 5) return "R6";
        if (e == 0 || s != k) return "R7";
        if (k == 4) return "R4";
        if (k == 5) return "R5";
        return "R3";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(start_o == '0, "R1 start after reset", int'(start_o), 0);
        rd_check(0, 0, "R1 level reset");
        rd_check(1, 0, "R1 enable reset");
        for (int c = 0; c < NCH; c++) rd_check(4 + c, 0, "R1 config reset");

        // R11 readback
        wr(1, 4'b1010); rd_check(1, 4'b1010, "R11 enable readback");
        wr(5, 5'b10_011); rd_check(5, 5'b10_011, "R11 config readback");
        wr(0, 4'b0110); rd_check(0, 4'b0110, "R11 level readback");
        wr(0, 0);
        lvl_v = '0;

        // R2 software start, no source selected
        for (int c = 0; c < NCH; c++) wr(4 + c, 5'b00_111);
        wr(1, 4'hF);
        fire(8, 4'b0101);
        for (int c = 0; c < NCH; c++) begin
            check(cnt[c] == (c % 2 == 0 ? 1 : 0), "R2 software start count", cnt[c], c % 2 == 0 ? 1 : 0);
            if (c % 2 == 0) check(first[c] == 2, "R2 software start cycle", first[c], 2);
        end
        rd_check(2, 0, "R2 software start reads zero");
        // R2 with a live hardware source selected
        wr(4, 5'b11_100);
        fire(8, 4'b0001);
        check(cnt[0] == 1, "R2 software start with timer selected", cnt[0], 1);

        // R9 four channels share the timer
        for (int c = 0; c < NCH; c++) wr(4 + c, 5'b01_100);
        fire(4, 1);
        for (int c = 0; c < NCH; c++) check(first[c] == 2 && cnt[c] == 1, "R9 shared source same cycle", first[c], 2);
        fire(4, 0);

        // R10 triggers while disabled are dropped
        wr(1, 4'b1110);
        fire(4, 1);
        check(cnt[0] == 0, "R10 disabled hw trigger", cnt[0], 0);
        fire(8, 4'b0001);
        check(cnt[0] == 0, "R10 disabled sw trigger", cnt[0], 0);
        wr(1, 4'hF);
        repeat (6) begin
            @(negedge clk);
            check(start_o[0] == 1'b0, "R10 no late start", int'(start_o[0]), 0);
        end
        fire(4, 0);

        // R3..R8 sweep over source codes and edge modes
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 4; e++) begin
                en_v = ((s + e) % 2 == 1) ? 4'b1011 : 4'b1111;
                for (int c = 0; c < NCH; c++) begin
                    src_c[c] = (s + c) % 8;
                    edg_c[c] = (e + c) % 4;
                    wr(4 + c, edg_c[c] * 8 + src_c[c]);
                end
                wr(1, int'(en_v));
                for (int k = 0; k < 6; k++) begin
                    for (int v = 1; v >= 0; v--) begin
                        fire(k, v);
                        for (int c = 0; c < NCH; c++) begin
                            automatic int ebit = (v == 1) ? (edg_c[c] & 1) : ((edg_c[c] >> 1) & 1);
                            automatic int exp = (en_v[c] && src_c[c] == k && ebit == 1) ? 1 : 0;
                            automatic int lat = (k == 5) ? 3 : 2;
                            automatic string t = en_v[c] ? tag_for(src_c[c], edg_c[c], k) : "R10";
                            check(cnt[c] == exp, {t, " R8 pulse count"}, cnt[c], exp);
                            if (exp == 1) check(first[c] == lat, {t, " pulse cycle"}, first[c], lat);
                        end
                    end
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule